// File: doc/BRIEF.md
# Serial Port Modem-Line Flow Control

This block sits beside an asynchronous serial port and applies modem-style handshaking to it. One input pin and one output pin, both active-low, are shared between flow control and a general-purpose function. With the master enable clear, the output pin carries a value supplied from outside and the synchronized input pin is handed back out for general use. With the enable set, two role bits decide what each pin means. The input pin is either a clear-to-send line that gates new transmit frames, or a request line that switches the receiver on and off. The output pin is either ready-to-send, which flags a pending transmit byte, or ready-to-receive, which flags that the receive register is free.

On the transmit side the block watches a frame-ready level from the transmitter. It issues a one-cycle start-frame pulse when a frame may begin, and then waits for a frame-done pulse before it decides again. The clear-to-send line is only looked at in the idle state, so a change part-way through a frame has no effect on that frame. On the receive side it takes the receiver's data-valid level and drives a receiver-enable level. The input pin passes through a two-flop synchronizer before any use. Reset is synchronous and active-high.

Top module: `uart_flowctl`

## Requirements
- R1: While rst is high, pin_out_n is 1 and tx_start is 0 from the next clock edge on, whatever alt_out_n and the other inputs do.
- R2: With fc_en = 0, pin_out_n equals alt_out_n one cycle later, alt_in_n equals pin_in_n after two clock edges, rx_en is 1, and a frame starts whatever level pin_in_n has. With fc_en = 1, alt_in_n is 1.
- R3: With fc_en = 1 and in_sel = 0 (clear-to-send role, active when pin_in_n = 0), a pending frame starts once the synchronized input is low. tx_start is high in the third cycle after pin_in_n falls, for exactly one cycle.
- R4: With fc_en = 1, in_sel = 0 and pin_in_n = 1, tx_start stays 0 however long tx_frame_rdy is held high.
- R5: The clear-to-send level is sampled only when a frame starts. Raising pin_in_n after tx_start does not stop that frame, and the next start waits for both tx_done and a low pin_in_n.
- R6: With fc_en = 1 and out_sel = 1 (ready-to-send role), pin_out_n is the inverse of tx_frame_rdy, delayed by one cycle.
- R7: With fc_en = 1 and out_sel = 0 (ready-to-receive role), pin_out_n equals rx_valid one cycle later. It goes high in the cycle after a byte becomes valid and low again after the byte is read.
- R8: With fc_en = 1 and in_sel = 1 (receiver-request role), rx_en equals the inverse of pin_in_n after two clock edges, and transmit frames are not gated by the pin.
- R9: At most one tx_start is issued per frame. After a start, no further start occurs until a tx_done pulse, and a start follows tx_done by two cycles when a frame is pending and the line is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_en | input | 1 | Master flow-control enable |
| in_sel | input | 1 | Input pin role: 0 clear-to-send, 1 receiver request |
| out_sel | input | 1 | Output pin role: 1 ready-to-send, 0 ready-to-receive |
| pin_in_n | input | 1 | Asynchronous active-low input pin |
| alt_in_n | output | 1 | Synchronized input pin for the general function (1 while flow control is on) |
| pin_out_n | output | 1 | Active-low output pin, registered |
| alt_out_n | input | 1 | General-function value driven on the output pin when flow control is off |
| tx_frame_rdy | input | 1 | Transmit holding register holds unsent data |
| tx_done | input | 1 | One-cycle pulse at the end of a transmitted frame |
| tx_start | output | 1 | One-cycle pulse telling the transmitter to begin a frame |
| rx_valid | input | 1 | Receive register holds unread data |
| rx_en | output | 1 | Receiver enable |

## Verification
The hardest case to reach is a change on the clear-to-send line while a frame is in flight. It needs a frame that was started while the line was low, then a rise of the pin within the same frame, and then a tx_done pulse that lands while the line is still high. The stimulus keeps tx_frame_rdy high the whole time so that a second byte is always pending. It toggles the pin only at known offsets from the start pulse. The scoreboard expects exactly one start in that window, and the next start two cycles after tx_done once the pin is back low. A second pass keeps the pin low through a whole frame to show that a pending byte alone cannot cause a second start before tx_done.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

    typedef enum logic {
        TXG_IDLE = 1'b0,
        TXG_SEND = 1'b1
    } txg_state_e;

    typedef struct packed {
        logic enable;
        logic in_role;   // 0: clear-to-send, 1: receiver request
        logic out_role;  // 1: ready-to-send, 0: ready-to-receive
    } fc_cfg_t;

    localparam logic PIN_IDLE = 1'b1;

    // Active-low level for the shared output pin.
    function automatic logic out_pin_level(fc_cfg_t cfg, logic frame_rdy,
                                           logic rx_full, logic alt_n);
        if (!cfg.enable)
            return alt_n;
        else if (cfg.out_role)
            return ~frame_rdy;
        else
            return rx_full;
    endfunction

    // Whether the transmitter may open a new frame.
    function automatic logic tx_clear(fc_cfg_t cfg, logic in_sync_n);
        return !cfg.enable || cfg.in_role || !in_sync_n;
    endfunction

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RESET_VAL;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RESET_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate
    import uart_fc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_rdy,
    input  logic clear,
    input  logic done,
    output logic start
);
    txg_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TXG_IDLE;
            start <= 1'b0;
        end else begin
            start <= 1'b0;
            case (state)
                TXG_IDLE: begin
                    if (frame_rdy && clear) begin
                        start <= 1'b1;
                        state <= TXG_SEND;
                    end
                end
                TXG_SEND: begin
                    if (done) state <= TXG_IDLE;
                end
                default: state <= TXG_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fc_pin_mux.sv
module fc_pin_mux
    import uart_fc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fc_cfg_t cfg,
    input  logic    frame_rdy,
    input  logic    rx_full,
    input  logic    alt_n,
    input  logic    in_sync_n,
    output logic    out_n,
    output logic    alt_in_n,
    output logic    rx_enable
);
    always_ff @(posedge clk) begin
        if (rst) out_n <= PIN_IDLE;
        else     out_n <= out_pin_level(cfg, frame_rdy, rx_full, alt_n);
    end

    assign alt_in_n  = cfg.enable ? PIN_IDLE : in_sync_n;
    assign rx_enable = (cfg.enable && cfg.in_role) ? !in_sync_n : 1'b1;
endmodule

// File: rtl/uart_flowctl.sv
module uart_flowctl
    import uart_fc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fc_en,
    input  logic in_sel,
    input  logic out_sel,
    input  logic pin_in_n,
    output logic alt_in_n,
    output logic pin_out_n,
    input  logic alt_out_n,
    input  logic tx_frame_rdy,
    input  logic tx_done,
    output logic tx_start,
    input  logic rx_valid,
    output logic rx_en
);
    fc_cfg_t cfg;
    logic    sync_n;
    logic    clear;

    assign cfg = '{enable: fc_en, in_role: in_sel, out_role: out_sel};

    fc_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(PIN_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in_n),
        .q   (sync_n)
    );

    assign clear = tx_clear(cfg, sync_n);

    fc_tx_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .frame_rdy (tx_frame_rdy),
        .clear     (clear),
        .done      (tx_done),
        .start     (tx_start)
    );

    fc_pin_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .frame_rdy (tx_frame_rdy),
        .rx_full   (rx_valid),
        .alt_n     (alt_out_n),
        .in_sync_n (sync_n),
        .out_n     (pin_out_n),
        .alt_in_n  (alt_in_n),
        .rx_enable (rx_en)
    );
endmodule

// File: rtl/uart_flowctl_checker.sv
module uart_flowctl_checker (
    input logic clk,
    input logic rst,
    input logic fc_en,
    input logic in_sel,
    input logic out_sel,
    input logic pin_in_n,
    input logic pin_out_n,
    input logic alt_out_n,
    input logic tx_frame_rdy,
    input logic tx_start,
    input logic rx_valid,
    input logic rx_en,
    input logic sync_n
);
    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (pin_out_n && !tx_start)); // R1

    AST_ALT_PASS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(fc_en)) |-> (pin_out_n == $past(alt_out_n))); // R2

    AST_START_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !$past(rst) && $past(fc_en) && !$past(in_sel)) |-> !$past(sync_n)); // R3

    AST_START_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        (tx_start && !$past(rst)) |-> $past(tx_frame_rdy)); // R4

    AST_RTS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fc_en) && $past(out_sel)) |-> (pin_out_n == !$past(tx_frame_rdy))); // R6

    AST_RTR_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(fc_en) && !$past(out_sel)) |-> (pin_out_n == $past(rx_valid))); // R7

    AST_RXEN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && fc_en && in_sel) |-> (rx_en == !$past(pin_in_n, 2))); // R8

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start); // R9
endmodule

bind uart_flowctl uart_flowctl_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .fc_en        (fc_en),
    .in_sel       (in_sel),
    .out_sel      (out_sel),
    .pin_in_n     (pin_in_n),
    .pin_out_n    (pin_out_n),
    .alt_out_n    (alt_out_n),
    .tx_frame_rdy (tx_frame_rdy),
    .tx_start     (tx_start),
    .rx_valid     (rx_valid),
    .rx_en        (rx_en),
    .sync_n       (sync_n)
);

// File: tb/uart_flowctl_test.sv
`timescale 1ns/100ps
module uart_flowctl_test;
    logic clk = 1'b0;
    logic rst, fc_en, in_sel, out_sel, pin_in_n, alt_out_n;
    logic tx_frame_rdy, tx_done, rx_valid;
    logic alt_in_n, pin_out_n, tx_start, rx_en;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int starts_seen = 0;
    bit finished = 0;
    int exp_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_flowctl uut (
        .clk(clk), .rst(rst), .fc_en(fc_en), .in_sel(in_sel), .out_sel(out_sel),
        .pin_in_n(pin_in_n), .alt_in_n(alt_in_n), .pin_out_n(pin_out_n),
        .alt_out_n(alt_out_n), .tx_frame_rdy(tx_frame_rdy), .tx_done(tx_done),
        .tx_start(tx_start), .rx_valid(rx_valid), .rx_en(rx_en)
    );

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // Driver side: record the cycle in which a start pulse must be seen.
    task automatic expect_start(int delta);
        exp_q.push_back(cyc + delta);
    endtask

    task automatic finish_frame();
        tx_done = 1'b1;
        step();
        tx_done = 1'b0;
    endtask

    // Monitor: compare each observed start against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && tx_start) begin
                int want;
                starts_seen++;
                checks++;
                if (exp_q.size() == 0) begin
                    failures++;
                    $display("FAIL R3/R4/R9 unexpected start actual=cycle %0d expected=none", cyc);
                end else begin
                    want = exp_q.pop_front();
                    if (want != cyc) begin
                        failures++;
                        $display("FAIL R3/R9 start cycle actual=%0d expected=%0d", cyc, want);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int base;
        rst = 1; fc_en = 0; in_sel = 0; out_sel = 0; pin_in_n = 1;
        alt_out_n = 0; tx_frame_rdy = 0; tx_done = 0; rx_valid = 0;
        step(3);
        chk("R1 pin_out_n in reset", pin_out_n, 1'b1);
        chk("R1 tx_start in reset", tx_start, 1'b0);
        rst = 0; alt_out_n = 1;
        step();

        // R2: flow control off
        alt_out_n = 0; step();
        chk("R2 alt passthrough low", pin_out_n, 1'b0);
        alt_out_n = 1; step();
        chk("R2 alt passthrough high", pin_out_n, 1'b1);
        pin_in_n = 0; step();
        chk("R2 alt_in_n after one edge", alt_in_n, 1'b1);
        step();
        chk("R2 alt_in_n after two edges", alt_in_n, 1'b0);
        chk("R2 rx_en forced on", rx_en, 1'b1);
        pin_in_n = 1; step(2);
        tx_frame_rdy = 1; expect_start(1); step();
        tx_frame_rdy = 0; step(3);
        finish_frame(); step();

        // R4: clear-to-send role, line high
        fc_en = 1; in_sel = 0; out_sel = 0; step();
        chk("R2 alt_in_n idle with fc on", alt_in_n, 1'b1);
        base = starts_seen;
        tx_frame_rdy = 1; step(10);
        chk("R4 no start while line high", (starts_seen == base), 1'b1);

        // R3: line falls, start three cycles later
        pin_in_n = 0; expect_start(3); step(3);
        chk("R3 start seen", (starts_seen == base + 1), 1'b1);
        // R5: line rises mid-frame; frame not stopped, no new start
        pin_in_n = 1; step(5);
        finish_frame(); step(5);
        chk("R5 no restart with line high after done", (starts_seen == base + 1), 1'b1);
        pin_in_n = 0; expect_start(3); step(3);
        // R9: line low and data pending, still one start until done
        step(6);
        chk("R9 single start per frame", (starts_seen == base + 2), 1'b1);
        tx_done = 1; expect_start(2); step(); tx_done = 0;
        step();
        tx_frame_rdy = 0; step(2);
        finish_frame(); step();
        chk("R9 start after done", (starts_seen == base + 3), 1'b1);

        // R6: ready-to-send role
        out_sel = 1; step();
        chk("R6 idle when nothing pending", pin_out_n, 1'b1);
        tx_frame_rdy = 1; expect_start(1); step();
        chk("R6 asserted with pending data", pin_out_n, 1'b0);
        tx_frame_rdy = 0; step();
        chk("R6 released when drained", pin_out_n, 1'b1);
        finish_frame(); step();

        // R7: ready-to-receive role
        out_sel = 0; step();
        chk("R7 ready when empty", pin_out_n, 1'b0);
        rx_valid = 1; step();
        chk("R7 not ready when byte held", pin_out_n, 1'b1);
        rx_valid = 0; step();
        chk("R7 ready after read", pin_out_n, 1'b0);

        // R8: receiver-request role
        in_sel = 1; pin_in_n = 1; step(2);
        chk("R8 receiver off with pin high", rx_en, 1'b0);
        pin_in_n = 0; step();
        chk("R8 still off after one edge", rx_en, 1'b0);
        step();
        chk("R8 receiver on after two edges", rx_en, 1'b1);
        chk("R8 alt_in_n idle", alt_in_n, 1'b1);
        pin_in_n = 1; step(2);
        tx_frame_rdy = 1; expect_start(1); step();
        tx_frame_rdy = 0; step(2);
        finish_frame(); step(4);

        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R3 missing starts actual=%0d pending expected=0", exp_q.size());
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule